// File: doc/BRIEF.md
# Calendar Time Counter with Encoding and Hour Modes

This block keeps wall-clock time and calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse on `sec_tick` requests an advance of one second. Carries ripple through every field in a single update, including month lengths and leap years.

Two mode inputs choose how the fields are held. With `bin_mode` high every field is a plain binary number; with it low every field is two packed BCD digits. With `h24_mode` high hours run 0 to 23; with it low they run 1 to 12, and bit 7 of the hour marks the afternoon. Each field rolls over in the encoding that is in force when the update happens.

Software stops the counters with `stop` while it loads new values through per-field write enables. Readers get a warning first: `uip` rises a fixed number of clock cycles (`LEAD_CYCLES`) before the fields change. A read that sees `uip` low therefore has at least that many cycles of stable data. A one-cycle `upd_done` pulse marks each completed update.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the fields read seconds 0, minutes 0, hour 0, day of week 1, date 1, month 1 and year 0, with `uip` and `upd_done` low.
- R2: A tick sampled with `stop` low and `uip` low raises `uip` on the next cycle. The fields keep their values for `LEAD_CYCLES` cycles and change at the edge where `uip` falls. `upd_done` is high for exactly the cycle after that edge. A tick that arrives while `uip` is high is ignored.
- R3: Seconds and minutes count 0 to 59 and wrap to 0 with a carry. In BCD (`bin_mode`=0) the tens digit sits in bits 6:4 and the units digit in bits 3:0. In binary (`bin_mode`=1) the top value is 0x3B and bits 7:6 are zero.
- R4: With `h24_mode`=1, hours count 0 to 23 (0x23 in BCD, 0x17 in binary), and wrapping to 0 starts a new day.
- R5: With `h24_mode`=0, hours count 1 to 12 and bit 7 is 1 for PM. The step from 11 to 12 toggles bit 7, and the step from 12 to 1 leaves it unchanged. The step from 11 PM to 12 AM starts a new day.
- R6: Day of week counts 1 to 7, wraps from 7 back to 1, and advances on the same update as the date.
- R7: The date wraps to 1 after the last day of the current month: 30 for months 4, 6, 9 and 11, 31 for the others, and for month 2 it is 29 when the year value is a multiple of 4 and 28 otherwise.
- R8: The month wraps from 12 to 1 and advances the year. The year wraps from 99 (0x99 in BCD, 0x63 in binary) to 0.
- R9: A tick sampled while `stop` is high causes no `uip`, no change and no `upd_done`. `stop` sampled high while `uip` is high drops `uip` and cancels that update.
- R10: A write enable is taken only while `stop` is high. It loads `wr_data` into one field, chosen by the bit of `wr_en`: bit 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 date, 5 month, 6 year. While `stop` is low, writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second advance request, one cycle wide |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode | input | 1 | 1 = 24-hour clock, 0 = 12-hour clock with PM flag |
| stop | input | 1 | Freeze counting and allow writes |
| wr_en | input | 7 | Per-field write enables |
| wr_data | input | 8 | Value loaded by a write |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour, bit 7 = PM in 12-hour mode |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| uip | output | 1 | Update pending warning |
| upd_done | output | 1 | One-cycle pulse after each completed update |

## Verification
The assertions watch four things on every cycle. The fields change only through a completed update or an accepted write. Seconds, minutes and hours are in range after every update under the mode in force. `uip` falls only through completion or a stop. `upd_done` never lasts longer than one cycle. Other properties need directed scenarios in the bench: the exact values at each carry boundary, month lengths and leap February, the 12-hour PM toggling, the exact lead time before a change, and the rule that writes are ignored while counting.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_time_t;

    localparam int FIELD_CNT = 7;

    // field value to plain number, per encoding
    function automatic logic [7:0] cal_dec(input logic [7:0] v, input logic bin);
        if (bin) return v;
        return 8'(int'(v[7:4]) * 10 + int'(v[3:0]));
    endfunction

    // plain number to field value, per encoding
    function automatic logic [7:0] cal_enc(input logic [7:0] n, input logic bin);
        if (bin) return n;
        return {4'(n / 8'd10), 4'(n % 8'd10)};
    endfunction

    function automatic logic [7:0] cal_month_days(input logic [7:0] mon, input logic [7:0] year);
        case (mon)
            8'd2:                    return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_seq.sv
module cal_seq #(
    parameter int LEAD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stop,
    output logic uip,
    output logic fire,
    output logic done
);
    localparam int CW = (LEAD_CYCLES < 2) ? 1 : $clog2(LEAD_CYCLES + 1);

    typedef struct packed {
        logic          uip;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        fire      = 1'b0;
        if (!st_q.uip) begin
            if (tick && !stop) begin
                st_d.uip = 1'b1;
                st_d.cnt = CW'(LEAD_CYCLES - 1);
            end
        end else if (stop) begin
            st_d.uip = 1'b0;
        end else if (st_q.cnt == '0) begin
            fire      = 1'b1;
            st_d.uip  = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign uip  = st_q.uip;
    assign done = st_q.done;

    assert_tick_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stop && !uip) |=> !uip);
    assert_uip_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> (done || $past(stop)));
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_uip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(uip));

endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  cal_time_t cur,
    input  logic      bin,
    input  logic      h24,
    output cal_time_t nxt
);
    logic [7:0] s, m, h, dw, dt, mo, yr, mdays;
    logic [7:0] ns, nm, nh, ndw, ndt, nmo, nyr;
    logic       c_min, c_hr, c_day, c_mon, c_yr, pm, npm;

    always_comb begin
        s     = cal_dec(cur.sec, bin);
        m     = cal_dec(cur.min, bin);
        h     = cal_dec({1'b0, cur.hour[6:0]}, bin);
        dw    = cal_dec(cur.dow, bin);
        dt    = cal_dec(cur.date, bin);
        mo    = cal_dec(cur.mon, bin);
        yr    = cal_dec(cur.year, bin);
        mdays = cal_month_days(mo, yr);
        pm    = cur.hour[7];

        ns = s; nm = m; nh = h; ndw = dw; ndt = dt; nmo = mo; nyr = yr;
        npm = pm;
        c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;

        if (s >= 8'd59) begin ns = 8'd0; c_min = 1'b1; end
        else            ns = s + 8'd1;

        if (c_min) begin
            if (m >= 8'd59) begin nm = 8'd0; c_hr = 1'b1; end
            else            nm = m + 8'd1;
        end

        if (c_hr) begin
            if (h24) begin
                if (h >= 8'd23) begin nh = 8'd0; c_day = 1'b1; end
                else            nh = h + 8'd1;
            end else if (h == 8'd11) begin
                nh    = 8'd12;
                npm   = !pm;
                c_day = pm;
            end else if (h >= 8'd12) begin
                nh = 8'd1;
            end else begin
                nh = h + 8'd1;
            end
        end

        if (c_day) begin
            if (dw >= 8'd7) ndw = 8'd1;
            else            ndw = dw + 8'd1;
            if (dt >= mdays) begin ndt = 8'd1; c_mon = 1'b1; end
            else             ndt = dt + 8'd1;
        end

        if (c_mon) begin
            if (mo >= 8'd12) begin nmo = 8'd1; c_yr = 1'b1; end
            else             nmo = mo + 8'd1;
        end

        if (c_yr) begin
            if (yr >= 8'd99) nyr = 8'd0;
            else             nyr = yr + 8'd1;
        end

        nxt.sec  = cal_enc(ns, bin);
        nxt.min  = cal_enc(nm, bin);
        if (h24) nxt.hour = cal_enc(nh, bin);
        else     nxt.hour = {npm, cal_enc(nh, bin)[6:0]};
        nxt.dow  = cal_enc(ndw, bin);
        nxt.date = cal_enc(ndt, bin);
        nxt.mon  = cal_enc(nmo, bin);
        nxt.year = cal_enc(nyr, bin);
    end

endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
    import cal_pkg::*;
#(
    parameter int LEAD_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_tick,
    input  logic                 bin_mode,
    input  logic                 h24_mode,
    input  logic                 stop,
    input  logic [FIELD_CNT-1:0] wr_en,
    input  logic [7:0]           wr_data,
    output logic [7:0]           sec_o,
    output logic [7:0]           min_o,
    output logic [7:0]           hour_o,
    output logic [7:0]           dow_o,
    output logic [7:0]           date_o,
    output logic [7:0]           month_o,
    output logic [7:0]           year_o,
    output logic                 uip,
    output logic                 upd_done
);
    localparam cal_time_t RESET_TIME = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                         dow: 8'h01, date: 8'h01, mon: 8'h01, year: 8'h00};

    cal_time_t time_q, time_d, adv;
    logic      fire;
    logic      wr_ok;

    cal_seq #(.LEAD_CYCLES(LEAD_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick),
        .stop  (stop),
        .uip   (uip),
        .fire  (fire),
        .done  (upd_done)
    );

    cal_advance u_adv (
        .cur (time_q),
        .bin (bin_mode),
        .h24 (h24_mode),
        .nxt (adv)
    );

    assign wr_ok = stop && (wr_en != '0);

    always_comb begin
        time_d = time_q;
        if (fire) time_d = adv;
        if (stop) begin
            if (wr_en[0]) time_d.sec  = wr_data;
            if (wr_en[1]) time_d.min  = wr_data;
            if (wr_en[2]) time_d.hour = wr_data;
            if (wr_en[3]) time_d.dow  = wr_data;
            if (wr_en[4]) time_d.date = wr_data;
            if (wr_en[5]) time_d.mon  = wr_data;
            if (wr_en[6]) time_d.year = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= RESET_TIME;
        else        time_q <= time_d;
    end

    assign sec_o   = time_q.sec;
    assign min_o   = time_q.min;
    assign hour_o  = time_q.hour;
    assign dow_o   = time_q.dow;
    assign date_o  = time_q.date;
    assign month_o = time_q.mon;
    assign year_o  = time_q.year;

    // R9 / R10: fields move only through a completed update or an accepted write
    assert_time_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (time_q != $past(time_q)) |-> ($past(fire) || $past(wr_ok)));
    assert_sec_min_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (cal_dec(sec_o, $past(bin_mode)) < 8'd60 &&
                      cal_dec(min_o, $past(bin_mode)) < 8'd60));
    assert_hour24_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && $past(h24_mode)) |-> (cal_dec(hour_o, $past(bin_mode)) < 8'd24));
    assert_hour12_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !$past(h24_mode)) |->
            (cal_dec({1'b0, hour_o[6:0]}, $past(bin_mode)) >= 8'd1 &&
             cal_dec({1'b0, hour_o[6:0]}, $past(bin_mode)) <= 8'd12));

endmodule

// File: tb/cal_clock_core_test.sv
module cal_clock_core_test;
    localparam int PERIOD = 10;
    localparam int LEAD   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       bin_mode = 1'b0;
    logic       h24_mode = 1'b1;
    logic       stop = 1'b0;
    logic [6:0] wr_en = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    logic       uip, upd_done;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    cal_clock_core #(.LEAD_CYCLES(LEAD)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bin_mode(bin_mode),
        .h24_mode(h24_mode), .stop(stop), .wr_en(wr_en), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o),
        .uip(uip), .upd_done(upd_done)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] v);
        @(negedge clk);
        wr_en   = 7'(1 << idx);
        wr_data = v;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic load(input logic [7:0] s, m, h, dw, dt, mo, y);
        @(negedge clk);
        stop = 1'b1;
        wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
        @(negedge clk);
        stop = 1'b0;
    endtask

    // one full update with timing checks (R2)
    task automatic run_update;
        logic [7:0] old_sec;
        old_sec = sec_o;
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk("R2 uip raised", {7'd0, uip}, 8'd1);
        repeat (LEAD - 1) @(negedge clk);
        chk("R2 stable during lead", sec_o, old_sec);
        chk("R2 uip still high", {7'd0, uip}, 8'd1);
        @(negedge clk);
        chk("R2 done pulse", {7'd0, upd_done}, 8'd1);
        chk("R2 uip low", {7'd0, uip}, 8'd0);
        @(negedge clk);
        chk("R2 done single", {7'd0, upd_done}, 8'd0);
    endtask

    task automatic t_reset;
        chk("R1 sec", sec_o, 8'h00);
        chk("R1 min", min_o, 8'h00);
        chk("R1 hour", hour_o, 8'h00);
        chk("R1 dow", dow_o, 8'h01);
        chk("R1 date", date_o, 8'h01);
        chk("R1 month", month_o, 8'h01);
        chk("R1 year", year_o, 8'h00);
        chk("R1 uip", {7'd0, uip}, 8'd0);
        chk("R1 done", {7'd0, upd_done}, 8'd0);
    endtask

    task automatic t_bcd24;
        bin_mode = 1'b0; h24_mode = 1'b1;
        load(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        run_update;
        chk("R3 bcd 09->10", sec_o, 8'h10);
        load(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        run_update;
        chk("R3 bcd 58->59", sec_o, 8'h59);
        run_update;
        chk("R3 sec wrap", sec_o, 8'h00);
        chk("R3 min wrap", min_o, 8'h00);
        chk("R4 hour wrap", hour_o, 8'h00);
        chk("R6 dow 7->1", dow_o, 8'h01);
        chk("R7 date 31->1", date_o, 8'h01);
        chk("R8 month 12->1", month_o, 8'h01);
        chk("R8 year 99->0", year_o, 8'h00);
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21);
        run_update;
        chk("R7 april 30->1", date_o, 8'h01);
        chk("R7 month 4->5", month_o, 8'h05);
        chk("R6 dow 2->3", dow_o, 8'h03);
    endtask

    task automatic t_binary;
        bin_mode = 1'b1; h24_mode = 1'b1;
        load(8'h09, 8'h00, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
        run_update;
        chk("R3 bin 09->0a", sec_o, 8'h0A);
        load(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h05);
        run_update;
        chk("R3 bin sec wrap", sec_o, 8'h00);
        chk("R4 bin hour wrap", hour_o, 8'h00);
        chk("R6 dow 3->4", dow_o, 8'h04);
        chk("R7 feb 28 common", date_o, 8'h01);
        chk("R7 month 2->3", month_o, 8'h03);
        load(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h08);
        run_update;
        chk("R7 leap feb 29", date_o, 8'h1D);
        chk("R7 leap month", month_o, 8'h02);
        load(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1F, 8'h0C, 8'h63);
        run_update;
        chk("R8 bin year wrap", year_o, 8'h00);
        chk("R8 bin month wrap", month_o, 8'h01);
    endtask

    task automatic t_12h;
        bin_mode = 1'b0; h24_mode = 1'b0;
        load(8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h03, 8'h10);
        run_update;
        chk("R5 11am->12pm", hour_o, 8'h92);
        chk("R5 no new day", date_o, 8'h05);
        load(8'h59, 8'h59, 8'h92, 8'h02, 8'h05, 8'h03, 8'h10);
        run_update;
        chk("R5 12pm->1pm", hour_o, 8'h81);
        load(8'h59, 8'h59, 8'h91, 8'h02, 8'h05, 8'h03, 8'h10);
        run_update;
        chk("R5 11pm->12am", hour_o, 8'h12);
        chk("R5 new day date", date_o, 8'h06);
        chk("R6 new day dow", dow_o, 8'h03);
        h24_mode = 1'b1;
    endtask

    task automatic t_stop;
        int done_seen;
        bin_mode = 1'b0;
        load(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        // tick while stopped
        @(negedge clk);
        stop = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk("R9 no uip when stopped", {7'd0, uip}, 8'd0);
        done_seen = 0;
        for (int i = 0; i < LEAD + 2; i++) begin
            @(negedge clk);
            if (upd_done) done_seen++;
        end
        chk("R9 no done when stopped", 8'(done_seen), 8'd0);
        chk("R9 frozen", sec_o, 8'h10);
        stop = 1'b0;
        // stop during uip cancels
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        chk("R9 abort drops uip", {7'd0, uip}, 8'd0);
        done_seen = 0;
        for (int i = 0; i < LEAD + 2; i++) begin
            @(negedge clk);
            if (upd_done) done_seen++;
        end
        chk("R9 abort no done", 8'(done_seen), 8'd0);
        chk("R9 abort no change", sec_o, 8'h10);
        stop = 1'b0;
    endtask

    task automatic t_writes;
        int done_seen;
        @(negedge clk);
        wr_en = 7'b0000001; wr_data = 8'h33;
        @(negedge clk);
        wr_en = '0;
        chk("R10 write ignored while running", sec_o, 8'h10);
        @(negedge clk);
        stop = 1'b1; wr_en = 7'b1000000; wr_data = 8'h42;
        @(negedge clk);
        wr_en = '0; stop = 1'b0;
        chk("R10 year written", year_o, 8'h42);
        chk("R10 sec untouched", sec_o, 8'h10);
        // second tick during uip ignored (R2)
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        done_seen = 0;
        for (int i = 0; i < 2 * LEAD + 4; i++) begin
            @(negedge clk);
            if (upd_done) done_seen++;
        end
        chk("R2 extra tick ignored", 8'(done_seen), 8'd1);
        chk("R2 single advance", sec_o, 8'h11);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_bcd24;
        t_binary;
        t_12h;
        t_stop;
        t_writes;
        summary;
    end

endmodule